// File: doc/BRIEF.md
# Sticky Fault Status Register Bank

This block gathers the raw outputs of a sensor's fault detectors and holds them in two 8-bit fault registers. Every detector line is first brought into the local clock domain by a multi-stage synchronizer. A fault bit latches on the first synchronized assertion and stays set after the detector drops. The master reads both registers together at one fixed address. A read returns the held bits and clears them in the same cycle. A fault that is still active at the clearing edge sets its bit again at once.

Some bits are built from others. A power bit in the low register sets whenever either regulator-voltage bit sets. A gross-failure bit in the high register follows the phase-lock fault. When a sensor data response is assembled, the block supplies two outputs: a copy of the low register, in which the self-test position also carries the amplitude fault, and a 2-bit status code. That code is 00 when a phase-lock fault is held. It is 10 when any other fault is held, and 01 when the response is clean.

Top module: `fault_latch_bank`

## Requirements
- R1: After reset every fault bit is clear, and with `rsp_stb_i` high the response status is 01 with a response fault byte of 0.
- R2: A detector assertion held across one clock edge becomes a visible fault bit after the second edge that follows it (`SYNC_STAGES`=2), and not before.
- R3: A latched fault bit stays set after its detector drops, for as long as no fault register read takes place.
- R4: When `rd_stb_i` is high and `rd_addr_i` equals `FAULT_ADDR` (default 0x0A), `rd_data_o` is {high, low}. High byte: bit 7 gross failure, bit 6 amplitude, bit 5 overvoltage, bit 4 undervoltage, bits 3..0 zero. Low byte: bit 7 phase lock, bit 6 quadrature, bit 5 memory checksum, bit 4 power-on check, bit 3 power, bit 2 self-test, bit 1 check, bit 0 zero. Otherwise `rd_data_o` is 0.
- R5: The clock edge of a matching read clears every bit whose synchronized detector is inactive. A strobe with any other address clears nothing.
- R6: A fault whose synchronized detector is still active at the clearing edge is set again right after that edge.
- R7: A fault whose synchronized detector first becomes active at the clearing edge is set after that edge; the set beats the clear.
- R8: The power bit (low bit 3) sets at the same edge as the overvoltage or undervoltage bit.
- R9: `rsp_fault_o` equals the low register, except that bit 2 is the OR of the self-test bit and the amplitude bit.
- R10: While the phase-lock bit is held, `rsp_status_o` is 00 and the gross-failure bit is set.
- R11: Without a phase-lock fault, `rsp_status_o` is 10 if the response fault byte is nonzero and 01 if it is zero.
- R12: While `rsp_stb_i` is low, both response outputs are 0. Building a response never clears a fault bit.

Detector input order (`det_i`): 0 check, 1 self-test, 2 power-on check, 3 memory checksum, 4 quadrature, 5 phase lock, 6 undervoltage, 7 overvoltage, 8 amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 9 | Raw asynchronous fault detector lines |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 16 | Fault registers {high, low} on a matching read |
| rsp_stb_i | input | 1 | Sensor data response build strobe |
| rsp_fault_o | output | 8 | Low fault byte for the response, with amplitude merged into bit 2 |
| rsp_status_o | output | 2 | Response status code |

## Verification
The assertions assume two things about the inputs. First, the detector lines reach the sticky bits only through the synchronizer. Second, a read strobe is judged purely by its address in the cycle it is high, so strobes may repeat back-to-back. The bench changes detector, strobe and address inputs only at the falling clock edge. It holds each detector either for whole cycles or as a single-cycle pulse. It times one assertion so that it reaches the synchronizer output exactly on a clearing read, which exercises the set-over-clear priority.

// File: rtl/fault_bank_pkg.sv
package fault_bank_pkg;
   localparam int NUM_DET = 9;
   localparam int REG_W   = 8;

   // detector input positions
   localparam int DI_CHK = 0;
   localparam int DI_CST = 1;
   localparam int DI_POR = 2;
   localparam int DI_NVM = 3;
   localparam int DI_Q   = 4;
   localparam int DI_PLL = 5;
   localparam int DI_UV  = 6;
   localparam int DI_OV  = 7;
   localparam int DI_AMP = 8;

   // low register positions
   localparam int LO_CHK = 1;
   localparam int LO_CST = 2;
   localparam int LO_PWR = 3;
   localparam int LO_POR = 4;
   localparam int LO_NVM = 5;
   localparam int LO_Q   = 6;
   localparam int LO_PLL = 7;

   // high register positions
   localparam int HI_UV   = 4;
   localparam int HI_OV   = 5;
   localparam int HI_AMP  = 6;
   localparam int HI_FAIL = 7;

   typedef enum logic [1:0] {
      ST_INVALID  = 2'b00,
      ST_VALID    = 2'b01,
      ST_DEGRADED = 2'b10
   } rsp_status_e;
endpackage

// File: rtl/flt_sync.sv
module flt_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("flt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/flt_sticky.sv
module flt_sticky #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] set_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (WIDTH < 1) begin : g_bad
         $error("flt_sticky: WIDTH must be positive");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         // set has priority over the read clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o[b] <= 1'b0;
            else if (clr_i) q_o[b] <= set_i[b];
            else            q_o[b] <= q_o[b] | set_i[b];
         end
      end
   endgenerate
endmodule

// File: rtl/flt_frame.sv
module flt_frame
   import fault_bank_pkg::*;
(
   input  logic             stb_i,
   input  logic [REG_W-1:0] lo_i,
   input  logic             amp_i,
   output logic [REG_W-1:0] fault_o,
   output logic [1:0]       status_o
);
   logic [REG_W-1:0] merged;
   rsp_status_e      code;

   always_comb begin
      merged         = lo_i;
      merged[LO_CST] = lo_i[LO_CST] | amp_i;
      if (lo_i[LO_PLL])      code = ST_INVALID;
      else if (merged != '0) code = ST_DEGRADED;
      else                   code = ST_VALID;
   end

   assign fault_o  = stb_i ? merged : '0;
   assign status_o = stb_i ? code : 2'b00;
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank
   import fault_bank_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] FAULT_ADDR  = 'h0A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_DET-1:0]   det_i,
   input  logic                 rd_stb_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   output logic [2*REG_W-1:0]   rd_data_o,
   input  logic                 rsp_stb_i,
   output logic [REG_W-1:0]     rsp_fault_o,
   output logic [1:0]           rsp_status_o
);
   localparam int BANK_W = 2 * REG_W;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("fault_latch_bank: ADDR_W too small for the fault address");
      end
   endgenerate

   logic [NUM_DET-1:0] sync_det;
   logic [REG_W-1:0]   set_lo, set_hi;
   logic [BANK_W-1:0]  bank_q;
   logic [REG_W-1:0]   fault_lo, fault_hi;
   logic               clr_hit;

   flt_sync #(.WIDTH(NUM_DET), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (det_i),
      .q_o   (sync_det)
   );

   always_comb begin
      set_lo          = '0;
      set_lo[LO_PLL]  = sync_det[DI_PLL];
      set_lo[LO_Q]    = sync_det[DI_Q];
      set_lo[LO_NVM]  = sync_det[DI_NVM];
      set_lo[LO_POR]  = sync_det[DI_POR];
      set_lo[LO_PWR]  = sync_det[DI_OV] | sync_det[DI_UV];
      set_lo[LO_CST]  = sync_det[DI_CST];
      set_lo[LO_CHK]  = sync_det[DI_CHK];
      set_hi          = '0;
      set_hi[HI_FAIL] = sync_det[DI_PLL];
      set_hi[HI_AMP]  = sync_det[DI_AMP];
      set_hi[HI_OV]   = sync_det[DI_OV];
      set_hi[HI_UV]   = sync_det[DI_UV];
   end

   assign clr_hit = rd_stb_i && (rd_addr_i == FAULT_ADDR);

   flt_sticky #(.WIDTH(BANK_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_hit),
      .set_i ({set_hi, set_lo}),
      .q_o   (bank_q)
   );

   assign fault_lo  = bank_q[REG_W-1:0];
   assign fault_hi  = bank_q[BANK_W-1:REG_W];
   assign rd_data_o = clr_hit ? bank_q : '0;

   flt_frame u_frame (
      .stb_i    (rsp_stb_i),
      .lo_i     (fault_lo),
      .amp_i    (fault_hi[HI_AMP]),
      .fault_o  (rsp_fault_o),
      .status_o (rsp_status_o)
   );
endmodule

// File: rtl/fault_latch_bank_chk.sv
module fault_latch_bank_chk
   import fault_bank_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               clr_hit,
   input logic               rsp_stb,
   input logic [NUM_DET-1:0] sync_det,
   input logic [REG_W-1:0]   fault_lo,
   input logic [REG_W-1:0]   fault_hi,
   input logic [REG_W-1:0]   rsp_fault,
   input logic [1:0]         rsp_status
);
   assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((fault_lo & $past(fault_lo)) == $past(fault_lo)) &&
                   ((fault_hi & $past(fault_hi)) == $past(fault_hi)));

   assert_clear_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && (sync_det == '0)) |=> (fault_lo == '0) && (fault_hi == '0));

   assert_reassert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && sync_det[DI_Q]) |=> fault_lo[LO_Q]);

   assert_pwr_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_hi[HI_OV] || fault_hi[HI_UV]) |-> fault_lo[LO_PWR]);

   assert_fail_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_lo[LO_PLL] |-> fault_hi[HI_FAIL]);

   assert_status_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_stb && fault_lo[LO_PLL]) |-> (rsp_status == 2'b00));

   assert_idle_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_stb |-> (rsp_fault == '0) && (rsp_status == 2'b00));
endmodule

bind fault_latch_bank fault_latch_bank_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_hit    (clr_hit),
   .rsp_stb    (rsp_stb_i),
   .sync_det   (sync_det),
   .fault_lo   (fault_lo),
   .fault_hi   (fault_hi),
   .rsp_fault  (rsp_fault_o),
   .rsp_status (rsp_status_o)
);

// File: tb/sim_fault_latch_bank.sv
`timescale 1ns/1ps
module sim_fault_latch_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  det = '0;
   logic        rd_stb = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        rsp_stb = 1'b1;
   logic [7:0]  rsp_fault;
   logic [1:0]  rsp_status;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fault_latch_bank u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .det_i        (det),
      .rd_stb_i     (rd_stb),
      .rd_addr_i    (rd_addr),
      .rd_data_o    (rd_data),
      .rsp_stb_i    (rsp_stb),
      .rsp_fault_o  (rsp_fault),
      .rsp_status_o (rsp_status)
   );

   // behavioural reference: delay line of detector samples plus named flags
   logic [8:0] pipe [$];
   logic [7:0] m_lo, m_hi;

   initial begin
      pipe = {9'h0, 9'h0};
      m_lo = '0;
      m_hi = '0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe = {9'h0, 9'h0};
         m_lo = '0;
         m_hi = '0;
      end else begin
         logic [8:0] sd;
         logic [7:0] s_lo, s_hi;
         sd = pipe.pop_front();
         pipe.push_back(det);
         s_lo = {sd[5], sd[4], sd[3], sd[2], sd[7] | sd[6], sd[1], sd[0], 1'b0};
         s_hi = {sd[5], sd[8], sd[7], sd[6], 4'b0000};
         if (rd_stb && rd_addr == 8'h0A) begin
            m_lo = s_lo;
            m_hi = s_hi;
         end else begin
            m_lo = m_lo | s_lo;
            m_hi = m_hi | s_hi;
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic compare_model();
      logic [7:0]  e_f;
      logic [1:0]  e_s;
      logic [15:0] e_rd;
      e_rd = (rd_stb && rd_addr == 8'h0A) ? {m_hi, m_lo} : 16'h0;
      e_f  = m_lo;
      e_f[2] = m_lo[2] | m_hi[6];
      if (m_lo[7])         e_s = 2'b00;
      else if (e_f != 0)   e_s = 2'b10;
      else                 e_s = 2'b01;
      if (!rsp_stb) begin
         e_f = '0;
         e_s = 2'b00;
      end
      chk("R4 R5 R6 R7 model rd_data", rd_data, e_rd);
      chk("R9 R12 model rsp_fault", {8'h0, rsp_fault}, {8'h0, e_f});
      chk("R10 R11 model rsp_status", {14'h0, rsp_status}, {14'h0, e_s});
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         compare_model();
      end
   endtask

   task automatic rd_clear();
      rd_addr = 8'h0A;
      rd_stb  = 1'b1;
      tick(1);
      rd_stb  = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements act=timeout exp=finished");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 reset status", {14'h0, rsp_status}, 16'h0001);
      chk("R1 reset fault byte", {8'h0, rsp_fault}, 16'h0000);

      // R2: single-cycle pulse on check detector
      det[0] = 1'b1;
      tick(1);
      det = '0;
      tick(1);
      chk("R2 not yet visible", {8'h0, rsp_fault}, 16'h0000);
      tick(1);
      chk("R2 visible", {8'h0, rsp_fault}, 16'h0002);

      // R3: held without a read
      tick(5);
      chk("R3 held", {8'h0, rsp_fault}, 16'h0002);

      // R5: wrong address does not clear
      rd_addr = 8'h08;
      rd_stb  = 1'b1;
      #1;
      chk("R4 unmatched read data", rd_data, 16'h0000);
      tick(1);
      rd_stb = 1'b0;
      chk("R5 wrong address keeps bit", {8'h0, rsp_fault}, 16'h0002);

      // R4/R5: matching read returns then clears
      rd_addr = 8'h0A;
      rd_stb  = 1'b1;
      #1;
      chk("R4 read data", rd_data, 16'h0002);
      tick(1);
      chk("R5 cleared", rd_data, 16'h0000);
      rd_stb = 1'b0;

      // R8/R6: overvoltage sets power, persists over a read
      det[7] = 1'b1;
      tick(3);
      chk("R8 power with overvoltage", {8'h0, rsp_fault}, 16'h0008);
      rd_stb = 1'b1;
      #1;
      chk("R4 R8 read overvoltage", rd_data, 16'h2008);
      tick(1);
      chk("R6 reasserted", rd_data, 16'h2008);
      rd_stb = 1'b0;
      det = '0;
      tick(3);
      rd_stb = 1'b1;
      #1;
      chk("R3 still held after drop", rd_data, 16'h2008);
      tick(1);
      chk("R5 cleared after drop", rd_data, 16'h0000);
      rd_stb = 1'b0;

      // R8: undervoltage
      det[6] = 1'b1;
      tick(3);
      chk("R8 power with undervoltage", {8'h0, rsp_fault}, 16'h0008);
      det = '0;
      tick(3);
      rd_clear();

      // R7: quadrature reaches synchronizer output on the clearing edge
      det[4] = 1'b1;
      tick(2);
      rd_clear();
      chk("R7 set wins over clear", {8'h0, rsp_fault}, 16'h0040);
      det = '0;
      tick(3);
      rd_clear();

      // R9/R11: amplitude merges into self-test position
      det[8] = 1'b1;
      tick(3);
      chk("R9 merged position", {8'h0, rsp_fault}, 16'h0004);
      chk("R11 degraded status", {14'h0, rsp_status}, 16'h0002);
      rd_stb = 1'b1;
      #1;
      chk("R9 separate in register", rd_data, 16'h4000);
      rd_stb = 1'b0;
      det = '0;
      tick(3);
      rd_clear();

      // R10: phase lock
      det[5] = 1'b1;
      tick(3);
      chk("R10 invalid status", {14'h0, rsp_status}, 16'h0000);
      rd_stb = 1'b1;
      #1;
      chk("R10 gross failure bit", rd_data, 16'h8080);
      rd_stb = 1'b0;
      det = '0;
      tick(3);
      rd_clear();
      chk("R11 valid after clear", {14'h0, rsp_status}, 16'h0001);

      // R12: response strobe gating and no clear
      det[0] = 1'b1;
      tick(3);
      det = '0;
      rsp_stb = 1'b0;
      #1;
      chk("R12 idle fault byte", {8'h0, rsp_fault}, 16'h0000);
      chk("R12 idle status", {14'h0, rsp_status}, 16'h0000);
      tick(4);
      rsp_stb = 1'b1;
      #1;
      chk("R12 strobe does not clear", {8'h0, rsp_fault}, 16'h0002);
      tick(2);
      summary();
   end
endmodule